// File: doc/BRIEF.md
# Table-Driven Power Sequencing Engine

This block is a state machine whose behaviour comes from a table that is loaded at run time. It moves through up to 64 numbered steps and drives a group of enable outputs. Each table row describes one step. A row holds the enable pattern for that step and a warning flag. It also holds three ways to leave the step: a sequence condition, a monitor condition and a step timeout. Each of these names its own destination step. With these rows, power-up ordering, power-down ordering, fault reactions and software-kicked watchdogs can all be built.

The engine looks at an event vector. This vector is made from the fault flags, the logic inputs and a software trigger bit. The step timer counts pulses on a tick input from the moment a step is entered. After every step change, the engine waits a fixed number of clock cycles before it may change step again. This gives a minimum time between state changes.

Top module: `pwr_seq_engine`

## Requirements
- R1: While `rst` is high, at the first clock edge the outputs are cleared (`state_o` = 0, `en_o` = 0, `irq_o` = 0) and the engine is placed in step 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` as the row of step `cfg_addr`. Writes are accepted during reset. The row is 87 bits wide. Its fields, listed from the top bit down, are:
  - enables [86:79]
  - warn [78]
  - seq_mask [77:65]
  - seq_pol [64:52]
  - mon_mask [51:39]
  - mon_pol [38:26]
  - seq_next [25:20]
  - mon_next [19:14]
  - tmo_next [13:8]
  - tmo_limit [7:0]

  The event vector is built as follows: bits 7..0 are `fault_i`, bits 11..8 are `logic_i`, and bit 12 is `sw_trig_i`.
- R3: `state_o` and `en_o` show the current step and its enable field. Both are updated at the clock edge after the edge at which the step changes. After reset is released, they show row 0 one cycle later.
- R4: The sequence condition is true when every event bit selected by seq_mask equals its bit in seq_pol. An all-zero mask disables the condition.
- R5: The monitor condition is true when any event bit selected by mon_mask equals its bit in mon_pol. An all-zero mask disables the condition.
- R6: When several conditions hold in the same decision cycle, the monitor condition is taken first, then the sequence condition, then the timeout.
- R7: The step timer counts clock cycles with `tick_i` high since the step was entered, and saturates at its maximum. The timeout is true when tmo_limit is not zero and the count is at least tmo_limit. A tmo_limit of zero never times out.
- R8: Two step changes are never closer than MIN_GAP clock cycles. Reset release counts as a change. If a condition is already true, the change takes effect exactly MIN_GAP cycles after the previous one.
- R9: A transition whose destination is the current step counts as a new entry: it restarts the step timer and the gap.
- R10: `irq_o` follows the warn bit of the current row, with the same timing as `en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table row write strobe |
| cfg_addr | input | 6 | Step number of the row being written |
| cfg_wdata | input | 87 | Row contents |
| fault_i | input | 8 | Supply fault flags (event bits 7..0) |
| logic_i | input | 4 | General logic inputs (event bits 11..8) |
| sw_trig_i | input | 1 | Software trigger bit (event bit 12) |
| tick_i | input | 1 | Timer tick, one count per cycle high |
| en_o | output | 8 | Enable outputs of the current step |
| state_o | output | 6 | Current step number |
| irq_o | output | 1 | Warning interrupt of the current step |

## Verification
The monitor, sequence and timeout conditions can all become true in the same decision cycle, namely the first cycle after the gap expires. The bench sets up this case by driving faults, the software trigger and ticks while reset is held. All three conditions are therefore already true when the window opens. The bench then judges the result by which step number appears on `state_o` exactly MIN_GAP+1 cycles after release, and checks that the step number did not change one cycle earlier. Self-re-entry racing against the timeout is covered in a second case: periodic kicks must keep the engine in its step, and the timeout must win once the kicks stop.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int ST_W  = 6;
  localparam int OUT_N = 8;
  localparam int FLT_N = 8;
  localparam int LOG_N = 4;
  localparam int EV_N  = FLT_N + LOG_N + 1;
  localparam int TMR_W = 8;

  typedef struct packed {
    logic [OUT_N-1:0] outs;
    logic             warn;
    logic [EV_N-1:0]  seq_mask;
    logic [EV_N-1:0]  seq_pol;
    logic [EV_N-1:0]  mon_mask;
    logic [EV_N-1:0]  mon_pol;
    logic [ST_W-1:0]  seq_nxt;
    logic [ST_W-1:0]  mon_nxt;
    logic [ST_W-1:0]  tmo_nxt;
    logic [TMR_W-1:0] tmo_lim;
  } step_t;

  localparam int STEP_W = $bits(step_t);
endpackage

// File: rtl/pseq_table_ram.sv
module pseq_table_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // single write port, registered read-first read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pseq_match.sv
module pseq_match #(
  parameter int W   = 13,
  parameter bit ANY = 1'b0
) (
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] pol_i,
  output logic         hit_o
);
  logic [W-1:0] eq;
  assign eq = ~(ev_i ^ pol_i);

  generate
    if (ANY) begin : g_any
      assign hit_o = |(mask_i & eq);
    end else begin : g_all
      assign hit_o = (|mask_i) && (&(eq | ~mask_i));
    end
  endgenerate
endmodule

// File: rtl/pseq_step_timer.sv
module pseq_step_timer #(
  parameter int TMR_W   = 8,
  parameter int MIN_GAP = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] lim_i,
  output logic             tmo_o,
  output logic             open_o
);
  localparam int GAP_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(MIN_GAP - 1);

  logic [GAP_W-1:0] hold_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      hold_q <= GAP_INIT;
      tmr_q  <= '0;
    end else begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      if (tick_i && (tmr_q != '1)) tmr_q <= tmr_q + 1'b1;
    end
  end

  assign open_o = (hold_q == '0);
  assign tmo_o  = (lim_i != '0) && (tmr_q >= lim_i);

  // R8: no step change is requested while the gap is still running
  a_r8_gap_respected: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0) |-> !load_i);

  // R7: the tick count moves by at most one per cycle between entries
  a_r7_timer_step: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ((tmr_q == $past(tmr_q)) || (tmr_q == $past(tmr_q) + 1'b1)));
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
  import pseq_pkg::*;
#(
  parameter int MIN_GAP = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ST_W-1:0]   cfg_addr,
  input  logic [STEP_W-1:0] cfg_wdata,
  input  logic [FLT_N-1:0]  fault_i,
  input  logic [LOG_N-1:0]  logic_i,
  input  logic              sw_trig_i,
  input  logic              tick_i,
  output logic [OUT_N-1:0]  en_o,
  output logic [ST_W-1:0]   state_o,
  output logic              irq_o
);
  logic [EV_N-1:0]   ev;
  logic [ST_W-1:0]   cur_q;
  logic [ST_W-1:0]   nxt;
  logic [STEP_W-1:0] rd_w;
  step_t             ent;
  logic              take;
  logic              seq_hit;
  logic              mon_hit;
  logic              tmo_hit;
  logic              open_w;

  assign ev  = {sw_trig_i, logic_i, fault_i};
  assign ent = step_t'(rd_w);

  pseq_table_ram #(.AW(ST_W), .DW(STEP_W)) u_table (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (nxt),
    .rdata (rd_w)
  );

  pseq_match #(.W(EV_N), .ANY(1'b0)) u_seq_match (
    .ev_i   (ev),
    .mask_i (ent.seq_mask),
    .pol_i  (ent.seq_pol),
    .hit_o  (seq_hit)
  );

  pseq_match #(.W(EV_N), .ANY(1'b1)) u_mon_match (
    .ev_i   (ev),
    .mask_i (ent.mon_mask),
    .pol_i  (ent.mon_pol),
    .hit_o  (mon_hit)
  );

  pseq_step_timer #(.TMR_W(TMR_W), .MIN_GAP(MIN_GAP)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (take),
    .tick_i (tick_i),
    .lim_i  (ent.tmo_lim),
    .tmo_o  (tmo_hit),
    .open_o (open_w)
  );

  // next-step choice: monitor, then sequence, then timeout
  always_comb begin
    nxt  = cur_q;
    take = 1'b0;
    if (rst) begin
      nxt = '0;
    end else if (open_w) begin
      if (mon_hit) begin
        nxt  = ent.mon_nxt;
        take = 1'b1;
      end else if (seq_hit) begin
        nxt  = ent.seq_nxt;
        take = 1'b1;
      end else if (tmo_hit) begin
        nxt  = ent.tmo_nxt;
        take = 1'b1;
      end
    end
  end

  // table row for nxt arrives in the same edge that cur_q takes nxt
  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= '0;
      state_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      en_o    <= ent.outs;
      state_o <= cur_q;
      irq_o   <= ent.warn;
    end
  end

  // R1: the cycle after a reset edge shows cleared outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (state_o == '0 && en_o == '0 && !irq_o));

  // R6: a monitor hit in an open window wins over all else
  a_r6_monitor_first: assert property (@(posedge clk) disable iff (rst)
    (open_w && mon_hit) |=> (cur_q == $past(ent.mon_nxt)));

  // R6: a sequence hit beats the timeout when no monitor hit
  a_r6_seq_over_tmo: assert property (@(posedge clk) disable iff (rst)
    (open_w && !mon_hit && seq_hit) |=> (cur_q == $past(ent.seq_nxt)));

  // R8: while the gap runs the step cannot move
  a_r8_no_early_move: assert property (@(posedge clk) disable iff (rst)
    !open_w |=> $stable(cur_q));
endmodule

// File: tb/pwr_seq_engine_test.sv
module pwr_seq_engine_test;
  localparam int CLK_P = 10;
  localparam int GAP   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [86:0] cfg_wdata = '0;
  logic [7:0]  fault_i = '0;
  logic [3:0]  logic_i = '0;
  logic        sw_trig_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  en_o;
  logic [5:0]  state_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwr_seq_engine #(.MIN_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fault_i(fault_i), .logic_i(logic_i),
    .sw_trig_i(sw_trig_i), .tick_i(tick_i), .en_o(en_o),
    .state_o(state_o), .irq_o(irq_o)
  );

  // row layout per R2
  function automatic logic [86:0] mk(
    input logic [7:0] outs, input logic warn,
    input logic [12:0] smask, input logic [12:0] spol,
    input logic [12:0] mmask, input logic [12:0] mpol,
    input logic [5:0] snx, input logic [5:0] mnx, input logic [5:0] tnx,
    input logic [7:0] lim);
    return {outs, warn, smask, spol, mmask, mpol, snx, mnx, tnx, lim};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [86:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1; fault_i = '0; logic_i = '0; sw_trig_i = 1'b0; tick_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic release_reset();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_state(input int exp, input int maxc, input string req);
    int n = 0;
    while (state_o != exp && n < maxc) begin
      @(negedge clk);
      n++;
    end
    chk(req, state_o, exp);
  endtask

  task automatic stay(input int exp, input int cyc, input string req);
    int bad = 0;
    int seen = exp;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (state_o != exp) begin
        bad++;
        seen = state_o;
      end
    end
    chk(req, seen, exp);
  endtask

  // R1, R2, R3, R10, R4/R5 disabled masks
  task automatic t_reset();
    hold_reset();
    wr(6'd0, mk(8'hA5, 1'b1, '0, '0, '0, '0, 6'd1, 6'd2, 6'd3, 8'd0));
    chk("R1 state in reset", state_o, 0);
    chk("R1 enables in reset", en_o, 0);
    chk("R1 irq in reset", irq_o, 0);
    release_reset();
    @(negedge clk);
    chk("R3 row0 enables after release", en_o, 8'hA5);
    chk("R10 irq from warn bit", irq_o, 1);
    fault_i = 8'hFF; logic_i = 4'hF; sw_trig_i = 1'b1; tick_i = 1'b1;
    stay(0, 20, "R4 R5 zero masks never move");
  endtask

  // R4 all-match with both polarities, R10
  task automatic t_sequence();
    hold_reset();
    logic_i = 4'h1;
    wr(6'd0, mk(8'h01, 1'b0, 13'h0003, 13'h0003, '0, '0, 6'd5, 6'd0, 6'd0, 8'd0));
    wr(6'd5, mk(8'h0F, 1'b0, 13'h0100, 13'h0000, '0, '0, 6'd6, 6'd0, 6'd0, 8'd0));
    wr(6'd6, mk(8'hF0, 1'b1, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    release_reset();
    fault_i = 8'h01;
    stay(0, 12, "R4 partial match holds");
    fault_i = 8'h03;
    wait_state(5, 10, "R4 full match moves");
    chk("R3 enables of step 5", en_o, 8'h0F);
    chk("R10 irq clear in step 5", irq_o, 0);
    stay(5, 10, "R4 low polarity not met");
    logic_i = 4'h0;
    wait_state(6, 10, "R4 low polarity met");
    chk("R3 enables of step 6", en_o, 8'hF0);
    chk("R10 irq set in step 6", irq_o, 1);
  endtask

  // R5, R6, R7, R8: conditions already true when window first opens
  task automatic t_prio(input logic [7:0] flt, input logic sw, input int exp, input string req);
    hold_reset();
    wr(6'd0, mk(8'h00, 1'b0, 13'h1000, 13'h1000, 13'h000C, 13'h000C, 6'd1, 6'd9, 6'd10, 8'd1));
    wr(6'd1, mk(8'h11, 1'b0, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    wr(6'd9, mk(8'h99, 1'b1, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    wr(6'd10, mk(8'hAA, 1'b0, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    fault_i = flt; sw_trig_i = sw; tick_i = 1'b1;
    release_reset();
    repeat (GAP) @(negedge clk);
    chk("R8 no move before gap", state_o, 0);
    @(negedge clk);
    chk(req, state_o, exp);
  endtask

  // R7 tick counting and zero limit
  task automatic t_timer();
    hold_reset();
    wr(6'd0, mk(8'h00, 1'b0, '0, '0, '0, '0, 6'd0, 6'd0, 6'd3, 8'd5));
    wr(6'd3, mk(8'h33, 1'b0, '0, '0, '0, '0, 6'd0, 6'd0, 6'd4, 8'd0));
    release_reset();
    repeat (6) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
    stay(0, 10, "R7 four ticks below limit");
    tick_i = 1'b1; @(negedge clk);
    tick_i = 1'b0;
    wait_state(3, 3, "R7 fifth tick times out");
    tick_i = 1'b1;
    stay(3, 40, "R7 zero limit never fires");
    tick_i = 1'b0;
  endtask

  // R8 spacing of back-to-back changes
  task automatic t_gap();
    int first1 = -1;
    int first2 = -1;
    int first3 = -1;
    hold_reset();
    wr(6'd0, mk(8'h01, 1'b0, 13'h1000, 13'h1000, '0, '0, 6'd1, 6'd0, 6'd0, 8'd0));
    wr(6'd1, mk(8'h02, 1'b0, 13'h1000, 13'h1000, '0, '0, 6'd2, 6'd0, 6'd0, 8'd0));
    wr(6'd2, mk(8'h04, 1'b0, 13'h1000, 13'h1000, '0, '0, 6'd3, 6'd0, 6'd0, 8'd0));
    wr(6'd3, mk(8'h08, 1'b0, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    sw_trig_i = 1'b1;
    release_reset();
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (state_o == 1 && first1 < 0) first1 = n;
      if (state_o == 2 && first2 < 0) first2 = n;
      if (state_o == 3 && first3 < 0) first3 = n;
    end
    chk("R8 first change after release", first1, GAP + 1);
    chk("R8 second change spacing", first2 - first1, GAP);
    chk("R8 third change spacing", first3 - first2, GAP);
    chk("R3 final enables", en_o, 8'h08);
  endtask

  // R9 self re-entry keeps a watchdog step alive
  task automatic t_watchdog();
    int bad = 0;
    hold_reset();
    wr(6'd0, mk(8'h00, 1'b0, 13'h1000, 13'h1000, '0, '0, 6'd1, 6'd0, 6'd0, 8'd0));
    wr(6'd1, mk(8'h3C, 1'b0, 13'h0200, 13'h0200, '0, '0, 6'd1, 6'd0, 6'd7, 8'd8));
    wr(6'd7, mk(8'h80, 1'b1, '0, '0, '0, '0, 6'd0, 6'd0, 6'd0, 8'd0));
    sw_trig_i = 1'b1; tick_i = 1'b1;
    release_reset();
    wait_state(1, 10, "R9 reach watchdog step");
    sw_trig_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic_i = 4'h2; @(negedge clk);
      if (state_o != 1) bad++;
      logic_i = 4'h0;
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        if (state_o != 1) bad++;
      end
    end
    chk("R9 kicks restart timer", bad, 0);
    wait_state(7, 14, "R9 timeout once kicks stop");
    chk("R10 irq in fault step", irq_o, 1);
    chk("R3 enables in fault step", en_o, 8'h80);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_prio(8'h08, 1'b1, 9, "R6 monitor beats sequence and timeout");
    t_prio(8'h04, 1'b0, 9, "R5 any selected fault triggers");
    t_prio(8'h00, 1'b1, 1, "R6 sequence beats timeout");
    t_prio(8'h00, 1'b0, 10, "R7 timeout taken alone");
    t_timer();
    t_gap();
    t_watchdog();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule